// File: doc/BRIEF.md
# Divisor-Based Oversampling Tick Generator

This block turns a reference into a single-cycle enable pulse whose rate is the reference rate divided by a 16-bit divisor. With the divisor chosen as reference frequency over sixteen times the line rate, the pulse drives the bit-timing logic of a serial transmitter and receiver. The divisor is held as two CPU-writable bytes, low and high. Each byte has its own write strobe and both share one data bus.

The reference is chosen at build time. It is either the system clock itself, one step per cycle, or an external baud clock. The external clock is brought into the system domain through a two-stage synchronizer, and each of its rising edges counts as one step while a qualifying enable input is high. A down-counter drives the divisor output. It is reloaded at the same clock edge that captures a divisor-byte write, so a new rate takes effect at once, with no leftover long count. A second output, `baud_out`, is a registered square-ish wave that is high for the first half of every divide period. A build-time switch can remove the generator altogether.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset both divisor bytes are zero, and `tick` and `baud_out` are low.
- R2: `div_lo_wr` loads `div_wdata` into divisor bits 7:0 and `div_hi_wr` loads it into bits 15:8. The byte that is not written keeps its value. Both strobes in one cycle load the same byte into both halves.
- R3: A divisor write captured at clock edge W reloads the counter at W and discards any partial count. With the system-clock reference and new divisor D (D >= 1), the first tick is registered at edge W+D.
- R4: `tick` is high for one cycle per reference step that ends a period, and periods repeat every D reference steps. Between two ticks there are D-1 steps with `tick` low when D >= 2.
- R5: With D = 1 and the system-clock reference, `tick` is high on every cycle after the first cycle following the write.
- R6: While the divisor is zero no tick is produced and `baud_out` stays low.
- R7: `baud_out` is high for the first ceil(D/2) reference steps of each period, counted from a reload, and low for the rest. It is high whenever `tick` is high.
- R8: With the external reference, each rising edge of `ext_baud_clk` seen through the two-stage synchronizer is one step while `ext_baud_en` is high. N edges after a reload yield floor(N/D) ticks. The external clock must run below half the system clock rate.
- R9: With the external reference, edges that arrive while `ext_baud_en` is low leave the count unchanged and produce no tick.
- R10: When the generator is disabled by parameter, `tick` and `baud_out` stay low whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_lo_wr | input | 1 | Write strobe for divisor low byte |
| div_hi_wr | input | 1 | Write strobe for divisor high byte |
| div_wdata | input | 8 | Byte written to the selected divisor half |
| ext_baud_clk | input | 1 | External reference clock, asynchronous |
| ext_baud_en | input | 1 | Qualifies external reference edges |
| tick | output | 1 | One-cycle pulse at reference rate divided by divisor |
| baud_out | output | 1 | Registered wave high for the first half of each period |

## Verification
The bench aims at the reload edge. If a design reloaded one cycle late, or let a partial count run out, the first tick after a write would arrive at the wrong cycle, and this shows most clearly in a write made mid-period. Divisors of one and zero are tried directly: an off-by-one terminal count would give a divide-by-two for one, and a missing zero guard would let the counter wrap and emit a tick every 65536 cycles. Single-byte writes catch a design that clears the other byte. External-source runs count ticks against synchronized edges with the enable both high and low, which exposes double counting of a level, counting with the enable low, and a lost count state.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    localparam int BYTE_W = 8;
    localparam int N_BYTES = 2;
    localparam int DIV_W = BYTE_W * N_BYTES;

    typedef logic [DIV_W-1:0] div_t;

    typedef enum logic {
        REF_SYSCLK = 1'b0,
        REF_EXTCLK = 1'b1
    } ref_src_e;

    typedef struct packed {
        logic              wr_lo;
        logic              wr_hi;
        logic [BYTE_W-1:0] data;
    } div_wr_t;

    typedef struct packed {
        div_t cnt;
        logic tick;
    } cnt_state_t;

    function automatic div_t half_of(input div_t d);
        return d >> 1;
    endfunction

    function automatic div_t merge_write(input div_t cur, input div_wr_t w);
        div_t r;
        r = cur;
        if (w.wr_lo) r[BYTE_W-1:0] = w.data;
        if (w.wr_hi) r[DIV_W-1:BYTE_W] = w.data;
        return r;
    endfunction

endpackage

// File: rtl/bg_div_regs.sv
module bg_div_regs
    import baudgen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  div_wr_t wr,
    output div_t    div_q,
    output div_t    div_next,
    output logic    reload
);

    always_comb begin
        div_next = merge_write(div_q, wr);
        reload   = wr.wr_lo | wr.wr_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (reload) begin
            div_q <= div_next;
        end
    end

    // R1: divisor cleared by reset
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (div_q == '0));

    // R2: low strobe lands in the low byte
    p_lo_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr.wr_lo |=> (div_q[BYTE_W-1:0] == $past(wr.data)));

    // R2: high byte kept on a low-only write
    p_hi_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (wr.wr_lo && !wr.wr_hi) |=> $stable(div_q[DIV_W-1:BYTE_W]));

    // R2: low byte kept on a high-only write
    p_lo_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (wr.wr_hi && !wr.wr_lo) |=> $stable(div_q[BYTE_W-1:0]));

endmodule

// File: rtl/bg_ref_qual.sv
module bg_ref_qual
    import baudgen_pkg::*;
#(
    parameter ref_src_e REF_SRC     = REF_SYSCLK,
    parameter int       SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  logic ext_en,
    output logic step
);

    generate
        if (REF_SRC == REF_SYSCLK) begin : g_sys
            logic unused_ref;
            assign unused_ref = ^{clk, rst, ext_clk, ext_en};
            assign step = 1'b1;
        end else begin : g_ext
            logic [SYNC_STAGES:0] sh;

            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[SYNC_STAGES-1:0], ext_clk};
            end

            assign step = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES] & ext_en;

            // R8: one step per synchronized rising edge
            p_step_single_r8: assert property (@(posedge clk) disable iff (rst)
                step |=> !step);

            // R9: no step while the qualifier is low
            p_en_gate_r9: assert property (@(posedge clk) disable iff (rst)
                !ext_en |-> !step);
        end
    endgenerate

endmodule

// File: rtl/bg_down_counter.sv
module bg_down_counter
    import baudgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic reload,
    input  div_t div_next,
    input  div_t div_q,
    output logic tick,
    output logic baud_out
);

    cnt_state_t st_q, st_d;
    div_t       div_eff;
    logic       bo_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        div_eff   = div_q;
        if (reload) begin
            st_d.cnt = div_next;
            div_eff  = div_next;
        end else if (step) begin
            if (st_q.cnt == div_t'(1)) begin
                st_d.cnt  = div_q;
                st_d.tick = 1'b1;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - div_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            bo_q <= 1'b0;
        end else begin
            st_q <= st_d;
            bo_q <= (st_d.cnt > half_of(div_eff));
        end
    end

    assign tick     = st_q.tick;
    assign baud_out = bo_q;

    // R3: counter holds the fresh divisor right after a write
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        reload |=> (st_q.cnt == $past(div_next)));

    // R4: count never exceeds the divisor
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= div_q);

    // R4: tick lasts one cycle when the divisor is above one
    p_tick_narrow_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q > div_t'(1)) |=> !tick);

    // R6: zero divisor is silent
    p_zero_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (div_q == '0) |-> (!tick && !baud_out));

    // R7: wave is high when the period restarts
    p_bo_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        tick |-> baud_out);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baudgen_pkg::*;
#(
    parameter ref_src_e REF_SRC     = REF_SYSCLK,
    parameter bit       GEN_EN      = 1'b1,
    parameter int       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              div_lo_wr,
    input  logic              div_hi_wr,
    input  logic [BYTE_W-1:0] div_wdata,
    input  logic              ext_baud_clk,
    input  logic              ext_baud_en,
    output logic              tick,
    output logic              baud_out
);

    generate
        if (GEN_EN) begin : g_gen
            div_wr_t wr;
            div_t    div_q;
            div_t    div_next;
            logic    reload;
            logic    step;

            assign wr = '{wr_lo: div_lo_wr, wr_hi: div_hi_wr, data: div_wdata};

            bg_div_regs u_regs (
                .clk      (clk),
                .rst      (rst),
                .wr       (wr),
                .div_q    (div_q),
                .div_next (div_next),
                .reload   (reload)
            );

            bg_ref_qual #(
                .REF_SRC     (REF_SRC),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_ref (
                .clk     (clk),
                .rst     (rst),
                .ext_clk (ext_baud_clk),
                .ext_en  (ext_baud_en),
                .step    (step)
            );

            bg_down_counter u_cnt (
                .clk      (clk),
                .rst      (rst),
                .step     (step),
                .reload   (reload),
                .div_next (div_next),
                .div_q    (div_q),
                .tick     (tick),
                .baud_out (baud_out)
            );
        end else begin : g_off
            logic unused_in;
            assign unused_in = ^{clk, rst, div_lo_wr, div_hi_wr, div_wdata,
                                 ext_baud_clk, ext_baud_en};
            assign tick     = 1'b0;
            assign baud_out = 1'b0;
        end
    endgenerate

endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
    import baudgen_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_lo_wr = 1'b0;
    logic       div_hi_wr = 1'b0;
    logic [7:0] div_wdata = '0;
    logic       ext_baud_clk = 1'b0;
    logic       ext_baud_en = 1'b1;
    logic       tick, baud_out;
    logic       tick_x, baud_x;
    logic       tick_o, baud_o;

    int checks = 0;
    int failures = 0;
    int ext_ticks = 0;
    int off_activity = 0;
    bit done = 1'b0;

    localparam int NV = 8;
    localparam int VEC_DIV [NV] = '{2, 3, 5, 16, 255, 256, 257, 4660};
    localparam int VEC_HI  [NV] = '{1, 2, 3, 8, 128, 128, 129, 2330};

    always #4 clk = ~clk;

    baud_tick_gen dut_i (
        .clk(clk), .rst(rst), .div_lo_wr(div_lo_wr), .div_hi_wr(div_hi_wr),
        .div_wdata(div_wdata), .ext_baud_clk(ext_baud_clk),
        .ext_baud_en(ext_baud_en), .tick(tick), .baud_out(baud_out));

    baud_tick_gen #(.REF_SRC(REF_EXTCLK)) dut_ext_i (
        .clk(clk), .rst(rst), .div_lo_wr(div_lo_wr), .div_hi_wr(div_hi_wr),
        .div_wdata(div_wdata), .ext_baud_clk(ext_baud_clk),
        .ext_baud_en(ext_baud_en), .tick(tick_x), .baud_out(baud_x));

    baud_tick_gen #(.GEN_EN(1'b0)) dut_off_i (
        .clk(clk), .rst(rst), .div_lo_wr(div_lo_wr), .div_hi_wr(div_hi_wr),
        .div_wdata(div_wdata), .ext_baud_clk(ext_baud_clk),
        .ext_baud_en(ext_baud_en), .tick(tick_o), .baud_out(baud_o));

    always @(negedge clk) begin
        if (tick_x) ext_ticks++;
        if (tick_o || baud_o) off_activity++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input bit lo, input bit hi, input logic [7:0] d);
        @(negedge clk);
        div_lo_wr = lo; div_hi_wr = hi; div_wdata = d;
        @(negedge clk);
        div_lo_wr = 1'b0; div_hi_wr = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] d);
        wr_byte(1'b0, 1'b1, d[15:8]);
        wr_byte(1'b1, 1'b0, d[7:0]);
    endtask

    // called at sample 0, the negedge right after the write edge
    task automatic measure(input int d, input int hi_exp, input string tag);
        int first = -1;
        int second = -1;
        int hi = 0;
        for (int j = 0; j <= 2 * d; j++) begin
            if (j > 0) @(negedge clk);
            if (tick) begin
                if (first < 0) first = j;
                else if (second < 0) second = j;
            end
            if (j < d && baud_out) hi++;
        end
        chk(first == d, {tag, " R3 first tick"}, first, d);
        chk(second == 2 * d, {tag, " R4 period"}, second, 2 * d);
        chk(hi == hi_exp, {tag, " R7 high steps"}, hi, hi_exp);
    endtask

    task automatic ext_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            repeat (4) @(negedge clk);
            ext_baud_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_baud_clk = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        int cnt;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(tick == 1'b0, "R1 tick after reset", int'(tick), 0);
        chk(baud_out == 1'b0, "R1 baud_out after reset", int'(baud_out), 0);

        // R6: zero divisor after reset gives nothing
        cnt = 0;
        for (int j = 0; j < 100; j++) begin
            @(negedge clk);
            if (tick || baud_out) cnt++;
        end
        chk(cnt == 0, "R6 silent at reset divisor", cnt, 0);

        // R3 R4 R7: table of divisors
        for (int i = 0; i < NV; i++) begin
            set_div(VEC_DIV[i][15:0]);
            measure(VEC_DIV[i], VEC_HI[i], "table");
        end

        // R5: divide by one
        set_div(16'd1);
        cnt = 0;
        chk(tick == 1'b0, "R5 no tick on write cycle", int'(tick), 0);
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            if (tick) cnt++;
        end
        chk(cnt == 20, "R5 tick every cycle", cnt, 20);

        // R3: mid-period write discards partial count
        set_div(16'd10);
        repeat (4) @(negedge clk);
        wr_byte(1'b1, 1'b0, 8'd6);
        measure(6, 3, "midperiod");

        // R2: low-only write keeps high byte -> 0x0105
        set_div(16'h0100);
        wr_byte(1'b1, 1'b0, 8'h05);
        measure(261, 131, "R2 lo-only");

        // R2: high-only write keeps low byte -> 0x0005
        wr_byte(1'b0, 1'b1, 8'h00);
        measure(5, 3, "R2 hi-only");

        // R2: both strobes -> 0x0202
        wr_byte(1'b1, 1'b1, 8'h02);
        measure(514, 257, "R2 both");

        // R6: back to zero stops ticks
        set_div(16'd7);
        set_div(16'd0);
        cnt = 0;
        for (int j = 0; j < 100; j++) begin
            if (j > 0) @(negedge clk);
            if (tick || baud_out) cnt++;
        end
        chk(cnt == 0, "R6 zero after nonzero", cnt, 0);

        // R8: external reference, divisor 3, 9 edges -> 3 ticks
        set_div(16'd3);
        repeat (8) @(negedge clk);
        base = ext_ticks;
        ext_pulses(9);
        chk(ext_ticks - base == 3, "R8 ext tick count", ext_ticks - base, 3);

        // R9: enable low, edges ignored
        ext_baud_en = 1'b0;
        base = ext_ticks;
        ext_pulses(8);
        chk(ext_ticks - base == 0, "R9 ext gated", ext_ticks - base, 0);

        // R9: count held through gated edges, 3 more edges -> 1 tick
        ext_baud_en = 1'b1;
        base = ext_ticks;
        ext_pulses(2);
        chk(ext_ticks - base == 0, "R9 ext held partial", ext_ticks - base, 0);
        ext_pulses(1);
        chk(ext_ticks - base == 1, "R9 ext resumes", ext_ticks - base, 1);

        // R10: disabled generator never active
        chk(off_activity == 0, "R10 disabled outputs", off_activity, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule